// File: doc/BRIEF.md
# External Bus Release Controller

This block hands a microcontroller's external bus to an outside master and takes it back. The outside master asks for the bus on an active-low request pin. That pin is resynchronised through two flip-flops. When the release enable is set, the block answers at the next bus-cycle boundary with an active-low acknowledge. At the same time it drops a pad drive enable, so the address, data and control pads float. While the bus is away, accesses that stay inside the chip carry on untouched.

An internal master that needs the external bus, and the refresh logic, each talk to the block through a request, a one-cycle grant and a done strobe. While the bus is released, both kinds of request are held back. If the give-back enable is set, a pending request drives an active-low give-back output that asks the outside master to let go. When the outside request clears, the acknowledge rises and held work resumes: refresh first, then the internal external access. A release request that arrives together with an internal external access wins.

Top module: `ext_bus_release`

## Requirements
- R1: After reset, bus_ack_n=1, pad_oe=1, giveback_n=1, and both grants are 0.
- R2: With rel_en=0, a low bus_req_n never lowers bus_ack_n or pad_oe, and internal grants keep being issued.
- R3: With rel_en=1 and the bus idle, a low level on bus_req_n (changed between clock edges) gives bus_ack_n=0 and pad_oe=0 after the third following rising edge, and not before it.
- R4: A release request seen while a granted external cycle or refresh is in progress waits until that cycle's done strobe; the release takes effect on the rising edge after the one that accepts the done strobe.
- R5: While released (bus_ack_n=0), ext_gnt and rfsh_gnt stay 0 whatever is requested.
- R6: While released, giveback_n is 0 exactly when giveback_en=1, the synchronised request is still asserted, and ext_req or rfsh_req is 1; otherwise it is 1.
- R7: When bus_req_n returns high, giveback_n goes high after the second rising edge, and bus_ack_n=1 and pad_oe=1 after the third.
- R8: If the synchronised release request and ext_req are both present while the bus is idle, ext_gnt stays 0 and the release is taken.
- R9: On an idle bus, a grant is a single-cycle pulse; when both are pending, rfsh_gnt is given first and ext_gnt only after the refresh's done strobe.
- R10: Between a grant and its done strobe no other grant is issued and no release is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rel_en | input | 1 | Allows the bus to be released |
| giveback_en | input | 1 | Allows the give-back output |
| bus_req_n | input | 1 | Active-low bus request from the outside master (asynchronous) |
| ext_req | input | 1 | Internal master wants an external access |
| ext_done | input | 1 | Internal master's external cycle finishes this cycle |
| rfsh_req | input | 1 | Refresh wants the bus |
| rfsh_done | input | 1 | Refresh cycle finishes this cycle |
| ext_gnt | output | 1 | One-cycle grant to the internal master |
| rfsh_gnt | output | 1 | One-cycle grant to the refresh logic |
| bus_ack_n | output | 1 | Active-low release acknowledge |
| pad_oe | output | 1 | 1 drives the external pads, 0 floats them |
| giveback_n | output | 1 | Active-low request for the outside master to let go |

## Verification
The hardest case to reach is a release request that lands while an internal external cycle is still open. The bench starts an access and holds off its done strobe while it lowers bus_req_n. It then waits several cycles to show the acknowledge stays high, and releases the done strobe to watch the handover edge. A second awkward case is the same-cycle race. Here the bench raises ext_req in the exact cycle in which the synchronised request first appears. The rest is a sweep over both enables and every mix of pending refresh and access, run through a full release and return.

// File: rtl/ext_bus_release.sv
module ext_bus_release (
  input  logic clk,
  input  logic rst_n,
  input  logic rel_en,
  input  logic giveback_en,
  input  logic bus_req_n,
  input  logic ext_req,
  input  logic ext_done,
  input  logic rfsh_req,
  input  logic rfsh_done,
  output logic ext_gnt,
  output logic rfsh_gnt,
  output logic bus_ack_n,
  output logic pad_oe,
  output logic giveback_n
);
  typedef enum logic [1:0] {IDLE, EXTC, RFSH, REL} st_t;
  st_t st, st_nx;
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin s1 <= 1'b1; s2 <= 1'b1; end
    else        begin s1 <= bus_req_n; s2 <= s1; end

  wire req_on  = ~s2;
  wire rel_win = rel_en & req_on;

  assign rfsh_gnt = (st == IDLE) & ~rel_win & rfsh_req;
  assign ext_gnt  = (st == IDLE) & ~rel_win & ~rfsh_req & ext_req;

  always_comb begin
    st_nx = st;
    case (st)
      IDLE: if (rel_win)       st_nx = REL;
            else if (rfsh_req) st_nx = RFSH;
            else if (ext_req)  st_nx = EXTC;
      EXTC: if (ext_done)      st_nx = IDLE;
      RFSH: if (rfsh_done)     st_nx = IDLE;
      REL:  if (!req_on)       st_nx = IDLE;
      default:                 st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= IDLE;
    else        st <= st_nx;

  assign bus_ack_n  = (st != REL);
  assign pad_oe     = (st != REL);
  assign giveback_n = ~((st == REL) & giveback_en & req_on & (ext_req | rfsh_req));

  a_r5_no_grant_released: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> !ext_gnt && !rfsh_gnt);
  a_r2_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_en && bus_ack_n |=> bus_ack_n);
  a_r9_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_gnt, rfsh_gnt}));
  a_r9_grant_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt || rfsh_gnt |=> !ext_gnt && !rfsh_gnt);
  a_r6_giveback_released: assert property (@(posedge clk) disable iff (!rst_n)
    !giveback_n |-> !bus_ack_n && giveback_en);
  a_r7_hold_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n && req_on |=> !bus_ack_n);
  a_r8_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE && rel_win |=> !bus_ack_n);
  a_r10_busy_no_release: assert property (@(posedge clk) disable iff (!rst_n)
    st == EXTC && !ext_done |=> bus_ack_n && !ext_gnt && !rfsh_gnt);
endmodule

// File: tb/tb_ext_bus_release.sv
module tb_ext_bus_release;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rel_en = 0, giveback_en = 0, bus_req_n = 1;
  logic ext_req = 0, ext_done = 0, rfsh_req = 0, rfsh_done = 0;
  logic ext_gnt, rfsh_gnt, bus_ack_n, pad_oe, giveback_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ext_bus_release dut (.*);

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #12; @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 ack", bus_ack_n, 1); chk("R1 oe", pad_oe, 1);
    chk("R1 giveback", giveback_n, 1); chk("R1 ext_gnt", ext_gnt, 0); chk("R1 rfsh_gnt", rfsh_gnt, 0);
    @(negedge clk);

    for (int c = 0; c < 16; c++) begin
      logic ren, roe, pr, pe;
      {ren, roe, pr, pe} = 4'(c);
      rel_en = ren; giveback_en = roe;
      bus_req_n = 0;
      tick(); tick();
      chk("R3 early ack", bus_ack_n, 1);
      tick();
      chk(ren ? "R3 ack" : "R2 ack", bus_ack_n, !ren);
      chk(ren ? "R3 oe" : "R2 oe", pad_oe, !ren);
      if (ren) begin
        rfsh_req = pr; ext_req = pe; #1;
        chk("R5 rfsh_gnt", rfsh_gnt, 0); chk("R5 ext_gnt", ext_gnt, 0);
        chk("R6 giveback", giveback_n, !(roe && (pr || pe)));
        tick();
        chk("R5 still released", bus_ack_n, 0);
        bus_req_n = 1;
        tick();
        chk("R6 giveback s1", giveback_n, !(roe && (pr || pe)));
        tick();
        chk("R7 giveback", giveback_n, 1); chk("R7 ack held", bus_ack_n, 0);
        tick();
        chk("R7 ack", bus_ack_n, 1); chk("R7 oe", pad_oe, 1);
        chk("R9 rfsh first", rfsh_gnt, pr); chk("R9 ext after", ext_gnt, pe && !pr);
        if (pr) begin
          tick(); rfsh_req = 0; #1;
          chk("R10 no grant in refresh", ext_gnt, 0);
          rfsh_done = 1; tick(); rfsh_done = 0; #1;
          chk("R9 ext after refresh", ext_gnt, pe);
        end
        if (pe) begin
          tick(); ext_req = 0; #1;
          chk("R9 pulse", ext_gnt, 0);
          ext_done = 1; tick(); ext_done = 0;
        end
      end else begin
        chk("R2 no giveback", giveback_n, 1);
        rfsh_req = pr; ext_req = pe; #1;
        chk("R2 rfsh_gnt", rfsh_gnt, pr); chk("R2 ext_gnt", ext_gnt, pe && !pr);
        if (pr || pe) begin
          tick(); rfsh_req = 0; ext_req = 0;
          rfsh_done = pr; ext_done = !pr; tick(); rfsh_done = 0; ext_done = 0;
        end
        bus_req_n = 1; tick(); tick(); tick();
      end
      tick();
    end

    rel_en = 1; giveback_en = 1;
    bus_req_n = 0; tick(); tick();
    ext_req = 1; #1;
    chk("R8 ext_gnt blocked", ext_gnt, 0);
    tick();
    chk("R8 release taken", bus_ack_n, 0);
    chk("R6 giveback pending", giveback_n, 0);
    bus_req_n = 1; tick(); tick(); tick(); #1;
    chk("R8 deferred ext granted", ext_gnt, 1);
    tick(); ext_req = 0;
    bus_req_n = 0;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk("R4 wait for done", bus_ack_n, 1);
      chk("R10 no grant busy", rfsh_gnt, 0);
    end
    ext_done = 1; tick(); ext_done = 0;
    chk("R4 not yet", bus_ack_n, 1);
    tick();
    chk("R4 release after done", bus_ack_n, 0);
    bus_req_n = 1; tick(); tick(); tick();
    chk("R7 final ack", bus_ack_n, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule